// File: doc/BRIEF.md
# Serial Receive Descrambler and Byte Packer

This block is the first stage of a serial receive path. On every clock it samples one data bit together with a data-enable level. A configuration input sets which enable level marks a bit as valid. Valid bits pass through a self-synchronous descrambler with the polynomial x^43 + 1, and a configuration input can bypass it. The resulting bit stream is then packed into bytes, either most-significant-bit first or least-significant-bit first.

The descrambled bit and its valid flag are also driven out, for a downstream bit-level deframer. Packet processing, such as flag search, bit destuffing and frame check, belongs to later stages and is not part of this block. Descrambling and byte packing stay active when those later stages are bypassed for clear-channel traffic.

Top module: `rx_serial_descram_front`

## Requirements
- R1: With `cfg_en_low` = 0, a bit is qualified when `ser_en` is 1. With `cfg_en_low` = 1, a bit is qualified when `ser_en` is 0. `bit_out_vld` is 1 exactly two clock edges after the edge that sampled a qualified bit.
- R2: With `cfg_descram_off` = 0, each qualified bit leaves as `bit_out` equal to the received bit XOR the received (scrambled) bit that was qualified 43 qualified bits earlier. Before 43 bits have been received since reset, that earlier bit is taken as 0.
- R3: With `cfg_descram_off` = 1, `bit_out` equals the received bit unchanged.
- R4: With `cfg_lsb_first` = 0, the first output bit of a byte lands in `byte_out[7]` and the eighth lands in `byte_out[0]`.
- R5: With `cfg_lsb_first` = 1, the first output bit of a byte lands in `byte_out[0]` and the eighth lands in `byte_out[7]`.
- R6: `byte_vld` pulses high for one clock, one edge after the `bit_out_vld` cycle of the eighth bit of a byte, and `byte_out` holds the assembled byte in that cycle. Bytes are counted from the first qualified bit after reset.
- R7: A bit sampled while the enable is inactive is ignored. It produces no `bit_out_vld`, and it advances neither the byte position nor the descrambler history.
- R8: Reset clears the outputs, the byte position and the descrambler history to 0. All configuration inputs are meant to be 0 after reset, which gives an active-high enable, descrambling on and MSB-first packing.
- R9: The descrambler history records every qualified bit even while bypassed. When the bypass is turned off mid-stream, output is correctly descrambled at once, with no resynchronisation gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en_low | input | 1 | 1: enable is active low |
| cfg_descram_off | input | 1 | 1: bypass the descrambler |
| cfg_lsb_first | input | 1 | 1: first bit of a byte goes to bit 0 |
| ser_data | input | 1 | Serial received data bit |
| ser_en | input | 1 | Data-enable level for `ser_data` |
| bit_out | output | 1 | Descrambled (or bypassed) serial bit |
| bit_out_vld | output | 1 | `bit_out` carries a qualified bit |
| byte_out | output | BYTE_W | Assembled byte |
| byte_vld | output | 1 | One-clock strobe marking `byte_out` valid |

## Verification
The assertions assume that reset is held for at least two clocks. They also assume that the configuration inputs change only while no qualified bit is in flight between the input and the byte output, because each pipeline stage reads the configuration at its own edge. The stimulus follows both rules. It asserts reset for three clocks, and before every configuration change it drives three cycles with the enable inactive. The bypass-to-descramble switch is then the only place where the stream continues across a change.

// File: rtl/rxfe_pkg.sv
package rxfe_pkg;
  // x^43 + 1 self-synchronous scrambler length
  localparam int unsigned HIST_LEN_DEF = 43;
  localparam int unsigned BYTE_W_DEF   = 8;

  typedef struct packed {
    logic en_low;
    logic descram_off;
    logic lsb_first;
  } rxfe_cfg_t;
endpackage

// File: rtl/rxfe_qualify.sv
module rxfe_qualify (
  input  logic clk,
  input  logic rst,
  input  logic en_low,
  input  logic ser_data,
  input  logic ser_en,
  output logic q_bit,
  output logic q_vld
);
  logic take;

  assign take = en_low ? ~ser_en : ser_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_bit <= 1'b0;
      q_vld <= 1'b0;
    end else begin
      q_vld <= take;
      if (take) q_bit <= ser_data;
    end
  end
endmodule

// File: rtl/rxfe_descram.sv
module rxfe_descram #(
  parameter int unsigned HIST_LEN = rxfe_pkg::HIST_LEN_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic bypass,
  input  logic in_bit,
  input  logic in_vld,
  output logic out_bit,
  output logic out_vld
);
  logic [HIST_LEN-1:0] hist;
  logic                tap;
  logic                clear_bit;

  assign tap       = hist[HIST_LEN-1];
  assign clear_bit = bypass ? in_bit : (in_bit ^ tap);

  // history holds received (scrambled) bits, advanced on qualified bits only
  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
    end else if (in_vld) begin
      hist <= {hist[HIST_LEN-2:0], in_bit};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_bit <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_bit <= clear_bit;
    end
  end

  // R7
  idle_hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(hist));
endmodule

// File: rtl/rxfe_packer.sv
module rxfe_packer #(
  parameter int unsigned BYTE_W = rxfe_pkg::BYTE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lsb_first,
  input  logic              in_bit,
  input  logic              in_vld,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_vld
);
  localparam int unsigned CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] next_sh;
  logic              at_last;

  assign at_last = (cnt == LAST);

  generate
    if (BYTE_W > 1) begin : g_wide
      always_comb begin
        if (lsb_first) next_sh = {in_bit, shreg[BYTE_W-1:1]};
        else           next_sh = {shreg[BYTE_W-2:0], in_bit};
      end
    end else begin : g_single
      always_comb next_sh = in_bit;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (in_vld) begin
      shreg <= next_sh;
      cnt   <= at_last ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_out <= '0;
      byte_vld <= 1'b0;
    end else begin
      byte_vld <= in_vld && at_last;
      if (in_vld && at_last) byte_out <= next_sh;
    end
  end

  // R6
  strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> $past(in_vld));
  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    (BYTE_W > 1 && byte_vld) |=> !byte_vld);
  // R7
  idle_cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(cnt));
  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/rx_serial_descram_front.sv
module rx_serial_descram_front #(
  parameter int unsigned HIST_LEN = rxfe_pkg::HIST_LEN_DEF,
  parameter int unsigned BYTE_W   = rxfe_pkg::BYTE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en_low,
  input  logic              cfg_descram_off,
  input  logic              cfg_lsb_first,
  input  logic              ser_data,
  input  logic              ser_en,
  output logic              bit_out,
  output logic              bit_out_vld,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_vld
);
  rxfe_pkg::rxfe_cfg_t cfg;
  logic q_bit, q_vld;

  assign cfg.en_low      = cfg_en_low;
  assign cfg.descram_off = cfg_descram_off;
  assign cfg.lsb_first   = cfg_lsb_first;

  rxfe_qualify u_qual (
    .clk      (clk),
    .rst      (rst),
    .en_low   (cfg.en_low),
    .ser_data (ser_data),
    .ser_en   (ser_en),
    .q_bit    (q_bit),
    .q_vld    (q_vld)
  );

  rxfe_descram #(.HIST_LEN(HIST_LEN)) u_descram (
    .clk     (clk),
    .rst     (rst),
    .bypass  (cfg.descram_off),
    .in_bit  (q_bit),
    .in_vld  (q_vld),
    .out_bit (bit_out),
    .out_vld (bit_out_vld)
  );

  rxfe_packer #(.BYTE_W(BYTE_W)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .lsb_first (cfg.lsb_first),
    .in_bit    (bit_out),
    .in_vld    (bit_out_vld),
    .byte_out  (byte_out),
    .byte_vld  (byte_vld)
  );

  // R1
  vld_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |->
      (bit_out_vld == ($past(ser_en, 2) ^ $past(cfg_en_low, 2))));
  // R3
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_descram_off) && bit_out_vld && !$past(rst, 2)) |->
      (bit_out == $past(ser_data, 2)));
endmodule

// File: tb/test_rx_serial_descram_front.sv
module test_rx_serial_descram_front;
  localparam int HL = 43;
  localparam int BW = 8;
  localparam int MAXB = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en_low = 1'b0, cfg_descram_off = 1'b0, cfg_lsb_first = 1'b0;
  logic ser_data = 1'b0, ser_en = 1'b0;
  logic bit_out, bit_out_vld, byte_vld;
  logic [BW-1:0] byte_out;

  int checks = 0;
  int failures = 0;

  // bench model state
  logic raw_hist [MAXB];
  int   nq;
  logic acc [BW];
  int   k;
  logic         bp_vld [2];
  logic         bp_bit [2];
  logic         yp_vld [3];
  logic [BW-1:0] yp_byte [3];
  string tag_bit, tag_vld, tag_byte;

  always #2.5 clk = ~clk;

  rx_serial_descram_front #(.HIST_LEN(HL), .BYTE_W(BW)) i_rx_serial_descram_front (
    .clk(clk), .rst(rst), .cfg_en_low(cfg_en_low), .cfg_descram_off(cfg_descram_off),
    .cfg_lsb_first(cfg_lsb_first), .ser_data(ser_data), .ser_en(ser_en),
    .bit_out(bit_out), .bit_out_vld(bit_out_vld), .byte_out(byte_out), .byte_vld(byte_vld)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_model();
    nq = 0; k = 0;
    for (int i = 0; i < 2; i++) begin bp_vld[i] = 0; bp_bit[i] = 0; end
    for (int i = 0; i < 3; i++) begin yp_vld[i] = 0; yp_byte[i] = '0; end
  endtask

  task automatic step(input logic d, input logic qual);
    logic o;
    logic [BW-1:0] b;
    logic done;
    @(negedge clk);
    chk(tag_vld, 32'(bit_out_vld), 32'(bp_vld[1]));
    if (bp_vld[1]) chk(tag_bit, 32'(bit_out), 32'(bp_bit[1]));
    chk("R6", 32'(byte_vld), 32'(yp_vld[2]));
    if (yp_vld[2]) chk(tag_byte, 32'(byte_out), 32'(yp_byte[2]));
    bp_vld[1] = bp_vld[0]; bp_bit[1] = bp_bit[0];
    yp_vld[2] = yp_vld[1]; yp_byte[2] = yp_byte[1];
    yp_vld[1] = yp_vld[0]; yp_byte[1] = yp_byte[0];
    ser_data = d;
    ser_en = qual ^ cfg_en_low;
    o = 0; done = 0; b = '0;
    if (qual) begin
      if (cfg_descram_off) o = d;
      else o = d ^ ((nq >= HL) ? raw_hist[nq-HL] : 1'b0);
      if (nq < MAXB) raw_hist[nq] = d;
      nq++;
      acc[k] = o; k++;
      if (k == BW) begin
        for (int j = 0; j < BW; j++)
          if (cfg_lsb_first) b[j] = acc[j]; else b[BW-1-j] = acc[j];
        done = 1; k = 0;
      end
    end
    bp_vld[0] = qual; bp_bit[0] = o;
    yp_vld[0] = done; yp_byte[0] = b;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ser_en = cfg_en_low; ser_data = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    clear_model();
    #1;
    // R8 reset state
    chk("R8", 32'(bit_out_vld), 0);
    chk("R8", 32'(bit_out), 0);
    chk("R8", 32'(byte_vld), 0);
    chk("R8", 32'(byte_out), 0);
  endtask

  task automatic run_bits(input int n, input int idle_mod);
    for (int i = 0; i < n; i++)
      step(1'($urandom % 2), (($urandom % idle_mod) != 0));
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_model();
    tag_bit = "R2"; tag_vld = "R7"; tag_byte = "R4";
    // sweep every configuration, reset between them
    for (int c = 0; c < 8; c++) begin
      cfg_en_low      = c[0];
      cfg_descram_off = c[1];
      cfg_lsb_first   = c[2];
      tag_vld  = cfg_en_low ? "R1" : "R7";
      tag_bit  = cfg_descram_off ? "R3" : "R2";
      tag_byte = cfg_lsb_first ? "R5" : "R4";
      do_reset();
      run_bits(160, 4);
      run_bits(40, 2);
      flush();
    end
    // R9: bypass first, then descramble without reset
    cfg_en_low = 0; cfg_descram_off = 1; cfg_lsb_first = 0;
    tag_vld = "R7"; tag_bit = "R9"; tag_byte = "R9";
    do_reset();
    run_bits(100, 3);
    flush();
    cfg_descram_off = 0;
    run_bits(100, 3);
    flush();
    // R8: reset mid-byte clears byte position and history
    run_bits(13, 5);
    tag_bit = "R8"; tag_byte = "R8";
    do_reset();
    run_bits(120, 4);
    flush();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule